// File: doc/BRIEF.md
# Channel Equalization Phase Controller

This block runs the second phase of training one hop of a display link, the phase that equalizes the channel. A supervisor pulses `start`. The controller then picks an equalization training pattern from the capability inputs it captures at that moment. It sends that pattern, with its scrambling control, in one write transaction to a sideband master. The same write carries the current per-lane drive bytes.

It then makes up to a fixed number of passes. Each pass waits a programmable delay and then reads the hop's status. Any active lane that has lost clock lock ends the phase at once with failure. If every active lane reports equalization done and symbol lock, and the lanes are aligned, the phase succeeds. Otherwise the controller writes the latest lane drive bytes, which logic outside the block computes, and starts the next pass. An error response on any transaction ends the phase with failure.

The number of passes started stays on `pass_cnt` after `done`. A supervisor can use it to tell a pass-limit failure from an early abort.

Top module: `eq_phase_ctrl`

## Requirements
- R1: The pattern field (bits [3:0] of the pattern byte) is 7, selecting pattern 4, when the source supports pattern 4 and either the sink supports it or `hop_is_rptr` is 1.
- R2: Failing R1, the field is 3 (pattern 3) when the source supports pattern 3 and either the sink supports it or `hop_is_rptr` is 1. In every other case the field is 2 (pattern 2).
- R3: Bit 5 of the pattern byte (scrambling off) is 1 for patterns 2 and 3 and 0 for pattern 4. Bits 4, 6 and 7 are 0.
- R4: The first request after `start` is op 0 (pattern write) with `sb_len` = lane_count+1. Byte 0 of `sb_wdata` is the pattern byte, and byte k (1..lane_count) is lane byte k-1 of `lane_set`. All higher bytes are 0.
- R5: Each pass begins after the ack of the preceding write. The pass waits DELAY_CYCLES clock cycles with no request, then issues op 1 (status read) with `sb_len` 0 and `sb_wdata` 0.
- R6: A status read whose active lanes do not all show `st_clk_lock` ends the phase with `done`=1 and `ok`=0. No further request follows, even if the equalization bits look complete.
- R7: A status read whose active lanes all show clock lock, equalization done and symbol lock, with `st_aligned` = 1, ends the phase with `ok`=1.
- R8: Any other status read causes op 2 (lane write) with `sb_len` = lane_count. Byte k (0..lane_count-1) of that write is lane byte k of `lane_set`, and all higher bytes are 0. After the write, the phase fails if MAX_PASSES passes have been made. Otherwise the next pass starts.
- R9: `sb_err` with the ack of any request ends the phase with `done`=1 and `ok`=0 on the next cycle.
- R10: Status bits of lanes at index lane_count and above have no effect.
- R11: `pass_cnt` counts the passes started since the last `start`. It never exceeds MAX_PASSES, is 0 after reset, and holds its value after `done`.
- R12: `sb_req` and its op stay asserted until `sb_ack`. `done` is a one-cycle pulse. After reset, `done`, `ok` and `sb_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a phase when idle |
| cap_src_p4 | input | 1 | Source supports pattern 4 |
| cap_snk_p4 | input | 1 | Sink supports pattern 4 |
| cap_src_p3 | input | 1 | Source supports pattern 3 |
| cap_snk_p3 | input | 1 | Sink supports pattern 3 |
| hop_is_rptr | input | 1 | The hop being trained is a repeater |
| lane_count | input | LCW | Active lanes, 1..MAX_LANES |
| lane_set | input | 8*MAX_LANES | Per-lane drive bytes, lane 0 in the low byte |
| st_clk_lock | input | MAX_LANES | Clock lock per lane, valid with a read ack |
| st_eq_done | input | MAX_LANES | Equalization done per lane |
| st_sym_lock | input | MAX_LANES | Symbol lock per lane |
| st_aligned | input | 1 | Interlane alignment |
| sb_req | output | 1 | Sideband request |
| sb_op | output | 2 | 0 pattern write, 1 status read, 2 lane write |
| sb_len | output | LENW | Bytes in the transfer |
| sb_wdata | output | 8*(MAX_LANES+1) | Write bytes, byte 0 low |
| sb_ack | input | 1 | Request completed |
| sb_err | input | 1 | Request failed, valid with ack |
| done | output | 1 | Phase finished, one cycle |
| ok | output | 1 | Phase result, valid with done |
| pass_cnt | output | PCW | Passes started |

## Verification
The bench builds the block with four lanes, a five-pass limit and a three-cycle delay. The short delay lets it run every pass up to the limit many times and measure the exact idle gap before each status read. Four lanes give room to try one, two and four active lanes. It can then place a lock loss on the highest active lane, and put misleading status on inactive lanes.

// File: rtl/eqp_pkg.sv
package eqp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG,
    S_WAIT,
    S_READ,
    S_EVAL,
    S_UPD,
    S_DONE
  } eqp_state_e;

  localparam logic [1:0] OP_WR_PAT  = 2'd0;
  localparam logic [1:0] OP_RD_ST   = 2'd1;
  localparam logic [1:0] OP_WR_LANE = 2'd2;

  localparam logic [3:0] PAT_SEL_2 = 4'd2;
  localparam logic [3:0] PAT_SEL_3 = 4'd3;
  localparam logic [3:0] PAT_SEL_4 = 4'd7;
  localparam int         SCR_OFF_BIT = 5;

endpackage

// File: rtl/eqp_pat_sel.sv
module eqp_pat_sel
  import eqp_pkg::*;
(
  input  logic       src_p4,
  input  logic       snk_p4,
  input  logic       src_p3,
  input  logic       snk_p3,
  input  logic       rptr,
  output logic [7:0] pat_byte
);

  logic p4_ok;
  logic p3_ok;

  // a repeater hop counts as capable on the sink side
  assign p4_ok = src_p4 & (snk_p4 | rptr);
  assign p3_ok = src_p3 & (snk_p3 | rptr);

  always_comb begin
    pat_byte = 8'h00;
    if (p4_ok) begin
      pat_byte[3:0] = PAT_SEL_4;
    end else begin
      pat_byte[3:0]       = p3_ok ? PAT_SEL_3 : PAT_SEL_2;
      pat_byte[SCR_OFF_BIT] = 1'b1;
    end
  end

endmodule

// File: rtl/eqp_lane_eval.sv
module eqp_lane_eval #(
  parameter int MAX_LANES = 4,
  localparam int LCW = $clog2(MAX_LANES + 1)
) (
  input  logic [LCW-1:0]       lanes,
  input  logic [MAX_LANES-1:0] clk_lock,
  input  logic [MAX_LANES-1:0] eq_done,
  input  logic [MAX_LANES-1:0] sym_lock,
  input  logic                 aligned,
  output logic                 cr_ok,
  output logic                 eq_ok
);

  logic [MAX_LANES-1:0] act_m;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_mask
    assign act_m[i] = (LCW'(i) < lanes);
  end

  assign cr_ok = &(clk_lock | ~act_m);
  assign eq_ok = cr_ok & (&((eq_done & sym_lock) | ~act_m)) & aligned;

endmodule

// File: rtl/eqp_wait_timer.sv
module eqp_wait_timer #(
  parameter int DELAY_CYCLES = 16,
  localparam int TW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = TW'(DELAY_CYCLES - 1);
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/eq_phase_ctrl.sv
module eq_phase_ctrl
  import eqp_pkg::*;
#(
  parameter int MAX_LANES    = 4,
  parameter int MAX_PASSES   = 5,
  parameter int DELAY_CYCLES = 400,
  localparam int LCW  = $clog2(MAX_LANES + 1),
  localparam int LENW = $clog2(MAX_LANES + 2),
  localparam int PCW  = $clog2(MAX_PASSES + 1),
  localparam int DW   = 8 * (MAX_LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   cap_src_p4,
  input  logic                   cap_snk_p4,
  input  logic                   cap_src_p3,
  input  logic                   cap_snk_p3,
  input  logic                   hop_is_rptr,
  input  logic [LCW-1:0]         lane_count,
  input  logic [8*MAX_LANES-1:0] lane_set,
  input  logic [MAX_LANES-1:0]   st_clk_lock,
  input  logic [MAX_LANES-1:0]   st_eq_done,
  input  logic [MAX_LANES-1:0]   st_sym_lock,
  input  logic                   st_aligned,
  output logic                   sb_req,
  output logic [1:0]             sb_op,
  output logic [LENW-1:0]        sb_len,
  output logic [DW-1:0]          sb_wdata,
  input  logic                   sb_ack,
  input  logic                   sb_err,
  output logic                   done,
  output logic                   ok,
  output logic [PCW-1:0]         pass_cnt
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign arst_n = rsync_q[1];

  eqp_state_e           state_q, state_d;
  logic [7:0]           pat_q;
  logic [7:0]           pat_sel;
  logic [LCW-1:0]       lanes_q;
  logic [PCW-1:0]       pcnt_q;
  logic                 ok_q, ok_d;
  logic [MAX_LANES-1:0] cr_q, eq_q, sym_q;
  logic                 al_q;

  logic cap_cfg, cap_st, clr_cnt, inc_cnt, ok_we, ld_tmr;
  logic tmr_expired, cr_ok, eq_ok;

  eqp_pat_sel i_pat_sel (
    .src_p4   (cap_src_p4),
    .snk_p4   (cap_snk_p4),
    .src_p3   (cap_src_p3),
    .snk_p3   (cap_snk_p3),
    .rptr     (hop_is_rptr),
    .pat_byte (pat_sel)
  );

  eqp_lane_eval #(.MAX_LANES(MAX_LANES)) i_lane_eval (
    .lanes    (lanes_q),
    .clk_lock (cr_q),
    .eq_done  (eq_q),
    .sym_lock (sym_q),
    .aligned  (al_q),
    .cr_ok    (cr_ok),
    .eq_ok    (eq_ok)
  );

  eqp_wait_timer #(.DELAY_CYCLES(DELAY_CYCLES)) i_wait_timer (
    .clk     (clk),
    .arst_n  (arst_n),
    .load    (ld_tmr),
    .run     (state_q == S_WAIT),
    .expired (tmr_expired)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cap_cfg = 1'b0;
    cap_st  = 1'b0;
    clr_cnt = 1'b0;
    inc_cnt = 1'b0;
    ok_we   = 1'b0;
    ok_d    = 1'b0;
    ld_tmr  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_PROG;
          cap_cfg = 1'b1;
          clr_cnt = 1'b1;
          ok_we   = 1'b1;
        end
      end
      S_PROG: begin
        if (sb_ack) begin
          if (sb_err) begin
            state_d = S_DONE;
          end else begin
            state_d = S_WAIT;
            inc_cnt = 1'b1;
            ld_tmr  = 1'b1;
          end
        end
      end
      S_WAIT: begin
        if (tmr_expired) begin
          state_d = S_READ;
        end
      end
      S_READ: begin
        if (sb_ack) begin
          if (sb_err) begin
            state_d = S_DONE;
          end else begin
            state_d = S_EVAL;
            cap_st  = 1'b1;
          end
        end
      end
      S_EVAL: begin
        if (!cr_ok) begin
          state_d = S_DONE;
        end else if (eq_ok) begin
          state_d = S_DONE;
          ok_we   = 1'b1;
          ok_d    = 1'b1;
        end else begin
          state_d = S_UPD;
        end
      end
      S_UPD: begin
        if (sb_ack) begin
          if (sb_err || (pcnt_q >= PCW'(MAX_PASSES))) begin
            state_d = S_DONE;
          end else begin
            state_d = S_WAIT;
            inc_cnt = 1'b1;
            ld_tmr  = 1'b1;
          end
        end
      end
      S_DONE: begin
        state_d = S_IDLE;
      end
      default: begin
        state_d = S_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= S_IDLE;
      pat_q   <= '0;
      lanes_q <= '0;
      pcnt_q  <= '0;
      ok_q    <= 1'b0;
      cr_q    <= '0;
      eq_q    <= '0;
      sym_q   <= '0;
      al_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_cfg) begin
        pat_q   <= pat_sel;
        lanes_q <= lane_count;
      end
      if (clr_cnt) begin
        pcnt_q <= '0;
      end else if (inc_cnt) begin
        pcnt_q <= pcnt_q + PCW'(1);
      end
      if (ok_we) begin
        ok_q <= ok_d;
      end
      if (cap_st) begin
        cr_q  <= st_clk_lock;
        eq_q  <= st_eq_done;
        sym_q <= st_sym_lock;
        al_q  <= st_aligned;
      end
    end
  end

  // sideband request fields
  assign sb_req = (state_q == S_PROG) || (state_q == S_READ) || (state_q == S_UPD);

  always_comb begin
    unique case (state_q)
      S_PROG:  begin sb_op = OP_WR_PAT;  sb_len = LENW'(lanes_q) + LENW'(1); end
      S_READ:  begin sb_op = OP_RD_ST;   sb_len = '0;                        end
      S_UPD:   begin sb_op = OP_WR_LANE; sb_len = LENW'(lanes_q);            end
      default: begin sb_op = OP_WR_PAT;  sb_len = '0;                        end
    endcase
  end

  for (genvar k = 0; k <= MAX_LANES; k++) begin : g_byte
    logic [7:0] pb;
    logic [7:0] ub;
    if (k == 0) begin : g_head
      assign pb = pat_q;
    end else begin : g_lane
      assign pb = (LCW'(k) <= lanes_q) ? lane_set[(k-1)*8 +: 8] : 8'h00;
    end
    if (k < MAX_LANES) begin : g_upd
      assign ub = (LCW'(k) < lanes_q) ? lane_set[k*8 +: 8] : 8'h00;
    end else begin : g_pad
      assign ub = 8'h00;
    end
    assign sb_wdata[k*8 +: 8] = (state_q == S_PROG) ? pb :
                                (state_q == S_UPD)  ? ub : 8'h00;
  end

  assign done     = (state_q == S_DONE);
  assign ok       = ok_q;
  assign pass_cnt = pcnt_q;

endmodule

// File: rtl/eqp_checker.sv
module eqp_checker
  import eqp_pkg::*;
#(
  parameter int MAX_LANES  = 4,
  parameter int MAX_PASSES = 5,
  localparam int LCW  = $clog2(MAX_LANES + 1),
  localparam int LENW = $clog2(MAX_LANES + 2),
  localparam int PCW  = $clog2(MAX_PASSES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [LCW-1:0]       lane_count,
  input logic [MAX_LANES-1:0] st_clk_lock,
  input logic [MAX_LANES-1:0] st_eq_done,
  input logic [MAX_LANES-1:0] st_sym_lock,
  input logic                 st_aligned,
  input logic                 sb_req,
  input logic [1:0]           sb_op,
  input logic [LENW-1:0]      sb_len,
  input logic [7:0]           wd_lo,
  input logic                 sb_ack,
  input logic                 sb_err,
  input logic                 done,
  input logic                 ok,
  input logic [PCW-1:0]       pass_cnt
);

  logic [MAX_LANES-1:0] act_m;
  logic                 cr_all, good_all, rd_ok_ack;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_m
    assign act_m[i] = (LCW'(i) < lane_count);
  end

  assign cr_all    = &(st_clk_lock | ~act_m);
  assign good_all  = cr_all & (&((st_eq_done & st_sym_lock) | ~act_m)) & st_aligned;
  assign rd_ok_ack = sb_req & sb_ack & ~sb_err & (sb_op == OP_RD_ST);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && !sb_ack) |=> (sb_req && $stable(sb_op) && $stable(sb_len)));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_cnt_max: assert property (@(posedge clk) disable iff (!rst_n)
    pass_cnt <= PCW'(MAX_PASSES));

  a_r3_scramble: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && sb_op == OP_WR_PAT) |-> (wd_lo[5] == (wd_lo[3:0] != PAT_SEL_4)));

  a_r4_pat_len: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && sb_op == OP_WR_PAT) |-> (sb_len == LENW'(lane_count) + LENW'(1)));

  a_r9_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && sb_ack && sb_err) |=> (done && !ok));

  a_r6_lock_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok_ack && !cr_all) |=> ##1 (done && !ok));

  a_r7_all_good: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok_ack && good_all) |=> ##1 (done && ok));

endmodule

bind eq_phase_ctrl eqp_checker #(
  .MAX_LANES  (MAX_LANES),
  .MAX_PASSES (MAX_PASSES)
) i_eqp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lane_count  (lane_count),
  .st_clk_lock (st_clk_lock),
  .st_eq_done  (st_eq_done),
  .st_sym_lock (st_sym_lock),
  .st_aligned  (st_aligned),
  .sb_req      (sb_req),
  .sb_op       (sb_op),
  .sb_len      (sb_len),
  .wd_lo       (sb_wdata[7:0]),
  .sb_ack      (sb_ack),
  .sb_err      (sb_err),
  .done        (done),
  .ok          (ok),
  .pass_cnt    (pass_cnt)
);

// File: tb/test_eq_phase_ctrl.sv
module test_eq_phase_ctrl;

  localparam int NL   = 4;
  localparam int NP   = 5;
  localparam int DL   = 3;
  localparam int LCW  = 3;
  localparam int LENW = 3;
  localparam int PCW  = 3;
  localparam int DW   = 40;

  typedef struct {
    logic [1:0]    op;
    logic [2:0]    len;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  typedef struct {
    logic       err;
    logic [3:0] cr;
    logic [3:0] eq;
    logic [3:0] sym;
    logic       al;
  } rsp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic c_s4, c_k4, c_s3, c_k3, c_rp;
  logic [LCW-1:0]  lane_count;
  logic [8*NL-1:0] lane_set;
  logic [NL-1:0]   st_cr, st_eq, st_sym;
  logic            st_al;
  logic            sb_req;
  logic [1:0]      sb_op;
  logic [LENW-1:0] sb_len;
  logic [DW-1:0]   sb_wdata;
  logic            sb_ack, sb_err;
  logic            done, ok;
  logic [PCW-1:0]  pass_cnt;

  int nchk = 0;
  int nerr = 0;
  int gap  = 0;
  exp_t exp_q[$];
  rsp_t rsp_q[$];
  exp_t cur_e;
  rsp_t cur_r;

  always #4 clk = ~clk;

  eq_phase_ctrl #(
    .MAX_LANES(NL), .MAX_PASSES(NP), .DELAY_CYCLES(DL)
  ) i_eq_phase_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cap_src_p4(c_s4), .cap_snk_p4(c_k4), .cap_src_p3(c_s3), .cap_snk_p3(c_k3),
    .hop_is_rptr(c_rp), .lane_count(lane_count), .lane_set(lane_set),
    .st_clk_lock(st_cr), .st_eq_done(st_eq), .st_sym_lock(st_sym), .st_aligned(st_al),
    .sb_req(sb_req), .sb_op(sb_op), .sb_len(sb_len), .sb_wdata(sb_wdata),
    .sb_ack(sb_ack), .sb_err(sb_err), .done(done), .ok(ok), .pass_cnt(pass_cnt)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic rsp_t mk(logic e, logic [3:0] cr, logic [3:0] eq,
                              logic [3:0] sym, logic al);
    rsp_t r;
    r.err = e; r.cr = cr; r.eq = eq; r.sym = sym; r.al = al;
    return r;
  endfunction

  // expected pattern byte from R1, R2, R3
  function automatic logic [7:0] model_pat();
    if (c_s4 && (c_k4 || c_rp)) return 8'h07;
    if (c_s3 && (c_k3 || c_rp)) return 8'h23;
    return 8'h22;
  endfunction

  task automatic push_prog(string tag, logic err);
    exp_t e;
    e.op = 2'd0; e.len = 3'(lane_count) + 3'd1; e.data = '0; e.tag = tag;
    e.data[7:0] = model_pat();
    for (int k = 1; k <= int'(lane_count); k++) e.data[k*8 +: 8] = lane_set[(k-1)*8 +: 8];
    exp_q.push_back(e);
    rsp_q.push_back(mk(err, 4'h0, 4'h0, 4'h0, 1'b0));
  endtask

  task automatic push_read(rsp_t r);
    exp_t e;
    e.op = 2'd1; e.len = 3'd0; e.data = '0; e.tag = "R5 status read";
    exp_q.push_back(e);
    rsp_q.push_back(r);
  endtask

  task automatic push_upd(logic err);
    exp_t e;
    e.op = 2'd2; e.len = 3'(lane_count); e.data = '0; e.tag = "R8 lane write";
    for (int k = 0; k < int'(lane_count); k++) e.data[k*8 +: 8] = lane_set[k*8 +: 8];
    exp_q.push_back(e);
    rsp_q.push_back(mk(err, 4'h0, 4'h0, 4'h0, 1'b0));
  endtask

  task automatic setup(logic s4, logic k4, logic s3, logic k3, logic rp,
                       int ln, logic [31:0] ls);
    c_s4 = s4; c_k4 = k4; c_s3 = s3; c_k3 = k3; c_rp = rp;
    lane_count = LCW'(ln);
    lane_set   = ls;
  endtask

  task automatic go(string tag, logic exp_ok, int exp_cnt);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk({tag, " ok"}, 64'(ok), 64'(exp_ok));
    chk("R11 pass count at done", 64'(pass_cnt), 64'(exp_cnt));
    repeat (4) @(negedge clk);
    chk("R11 pass count held", 64'(pass_cnt), 64'(exp_cnt));
    chk("R6 R8 all expected requests seen", 64'(exp_q.size()), 64'd0);
    chk("R12 done is one cycle", 64'(done), 64'd0);
  endtask

  // sideband responder and scoreboard monitor
  initial begin
    sb_ack = 1'b0; sb_err = 1'b0;
    st_cr = '0; st_eq = '0; st_sym = '0; st_al = 1'b0;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (sb_req) begin
        if (exp_q.size() == 0) begin
          nchk++; nerr++;
          $display("FAIL R6 unexpected request op=%0h expected none", sb_op);
          cur_r = mk(1'b1, 4'h0, 4'h0, 4'h0, 1'b0);
        end else begin
          cur_e = exp_q.pop_front();
          cur_r = rsp_q.pop_front();
          chk({cur_e.tag, " op"}, 64'(sb_op), 64'(cur_e.op));
          chk({cur_e.tag, " len"}, 64'(sb_len), 64'(cur_e.len));
          chk({cur_e.tag, " data"}, 64'(sb_wdata), 64'(cur_e.data));
          if (cur_e.op == 2'd1) chk("R5 delay before read", 64'(gap), 64'(DL));
        end
        repeat (2) begin
          @(negedge clk);
          if (!sb_req) begin
            nchk++; nerr++;
            $display("FAIL R12 request dropped before ack actual=0 expected=1");
          end
        end
        sb_ack = 1'b1; sb_err = cur_r.err;
        st_cr = cur_r.cr; st_eq = cur_r.eq; st_sym = cur_r.sym; st_al = cur_r.al;
        @(negedge clk);
        sb_ack = 1'b0; sb_err = 1'b0;
        gap = sb_req ? 0 : 1;
      end else begin
        gap++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    setup(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1, 32'h0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 reset done", 64'(done), 64'd0);
    chk("R12 reset ok", 64'(ok), 64'd0);
    chk("R12 reset req", 64'(sb_req), 64'd0);
    chk("R11 reset count", 64'(pass_cnt), 64'd0);

    // R1: pattern 4 on sink support, first pass good -> R7
    setup(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4, 32'h0A0B0C0D);
    push_prog("R1 R4 pattern write", 1'b0);
    push_read(mk(1'b0, 4'hF, 4'hF, 4'hF, 1'b1));
    go("R7 pass first try", 1'b1, 1);

    // R1: repeater stands in for sink support; two retries then good
    setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2, 32'h11223344);
    push_prog("R1 R4 repeater pattern 4", 1'b0);
    push_read(mk(1'b0, 4'hF, 4'hF, 4'hE, 1'b1));
    push_upd(1'b0);
    push_read(mk(1'b0, 4'hF, 4'hF, 4'hF, 1'b0));
    push_upd(1'b0);
    push_read(mk(1'b0, 4'hF, 4'hF, 4'hF, 1'b1));
    go("R7 R8 pass third try", 1'b1, 3);

    // R2 R3: pattern 3, pass limit reached, one lane
    setup(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1, 32'h00000055);
    push_prog("R2 R3 pattern 3", 1'b0);
    for (int p = 0; p < NP; p++) begin
      push_read(mk(1'b0, 4'hF, 4'hF, 4'hE, 1'b1));
      push_upd(1'b0);
    end
    go("R8 pass limit fail", 1'b0, NP);

    // R2: pattern 2 when sinks lack support; lock lost on the top lane
    setup(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4, 32'h01020304);
    push_prog("R2 R3 pattern 2", 1'b0);
    push_read(mk(1'b0, 4'hF, 4'h7, 4'hF, 1'b1));
    push_upd(1'b0);
    push_read(mk(1'b0, 4'h7, 4'hF, 4'hF, 1'b1));
    go("R6 lock loss fail", 1'b0, 2);

    // R2: source lacks pattern 3 -> pattern 2; read error
    setup(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4, 32'hA1B2C3D4);
    push_prog("R2 pattern 2 source limited", 1'b0);
    push_read(mk(1'b1, 4'hF, 4'hF, 4'hF, 1'b1));
    go("R9 read error", 1'b0, 1);

    // repeater gives pattern 3; update write error
    setup(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2, 32'h99887766);
    push_prog("R2 repeater pattern 3", 1'b0);
    push_read(mk(1'b0, 4'hF, 4'hE, 4'hF, 1'b1));
    push_upd(1'b1);
    go("R9 update error", 1'b0, 1);

    // pattern write error
    setup(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4, 32'h5A5A5A5A);
    push_prog("R1 pattern write before error", 1'b1);
    go("R9 pattern write error", 1'b0, 0);

    // R10: inactive lanes report nothing, phase still passes
    setup(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2, 32'hDEADBEEF);
    push_prog("R2 R4 two lanes", 1'b0);
    push_read(mk(1'b0, 4'h3, 4'h3, 4'h3, 1'b1));
    go("R10 inactive lanes ignored", 1'b1, 1);

    // R6: lock loss wins even when equalization looks complete
    setup(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4, 32'h12345678);
    push_prog("R1 R4 four lanes", 1'b0);
    push_read(mk(1'b0, 4'hD, 4'hF, 4'hF, 1'b1));
    go("R6 lock loss priority", 1'b0, 1);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule